// File: doc/BRIEF.md
# Data-Transform Protection and OR-Banking Unit

This block stands in a cartridge-side address path and does two things. It holds an 8-bit data value and a 2-bit command. A CPU read from the protection window returns that data value after one of four fixed bit transforms, chosen by the command. This lets software confirm that the protection hardware is present.

It also holds a bank value with a granularity of 32 KB. The bank is applied to every CPU address in the first megabyte of the address space to form the physical ROM address. The bank is merged into the address by a bitwise OR, not by an addition.

A bank write is refused when the selected bank would reach past the end of the ROM. In that case the old bank is kept and a reject flag is raised for one cycle. The ROM size comes in on an input port. The ROM itself lies outside the block.

Top module: `xform_orbank_unit`

## Requirements
- R1: A byte write to the protection page (cpu_addr[23:20] == 6) with cpu_addr[1] = 1 stores only wr_data[1:0] as the command. With cpu_addr[1] = 0, it stores all of wr_data as the data value.
- R2: With command 0, a read returns the data shifted left by one, truncated to 8 bits with bit 0 cleared. With command 1, it returns the data shifted right by one with bit 7 cleared.
- R3: With command 2, a read returns the data with its upper and lower nibbles exchanged.
- R4: With command 3, a read returns the data with its bit order mirrored: result bit i equals data bit 7-i.
- R5: rd_data carries the transform result when cpu_addr[23:21] == 3'b011 (0x600000 to 0x7FFFFF). At any other address it is 0.
- R6: A byte write to the bank page (cpu_addr[23:20] == 7) sets the bank to wr_data * 0x8000. For cpu_addr < 0x100000, phys_addr equals cpu_addr OR bank. At all other addresses, phys_addr equals cpu_addr.
- R7: A bank write for which wr_data * 0x8000 + 0x10000 >= rom_size leaves the bank unchanged and raises bank_reject in the following cycle. An accepted write, or no write, leaves bank_reject low in the following cycle.
- R8: Reset sets the data value, the command and the bank to zero.
- R9: Reads are combinational from the stored registers. A write becomes visible on rd_data and phys_addr in the cycle after the clock edge that takes it.
- R10: A protection-page write does not change the bank. A bank-page write does not change the data value or the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| wr_en | input | 1 | Byte write strobe, valid for one cycle |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Transformed readback, 0 outside the read window |
| rom_size | input | 25 | ROM size in bytes, used for the bank bound check |
| phys_addr | output | 24 | Physical ROM address after OR-banking |
| bank_reject | output | 1 | High for one cycle after a refused bank write |

## Verification
The bank page lies inside the read window. A single bank-page write is therefore both a bank update and a protection readback in the same cycle. The bench provokes this on every bank write: it samples rd_data while the bank write is held on the bus and expects the transform of the data value written earlier, unchanged by the write. It then checks in the next cycle that the data value and the command still hold, while phys_addr shows the new or kept bank. The data/command sweep runs across all 1024 combinations, and the bank sweep covers all 256 bank bytes at three ROM sizes, including the exact boundary where the bound check first refuses.

// File: rtl/porb_pkg.sv
package porb_pkg;
   typedef enum logic [1:0] {
      XF_SHL   = 2'd0,
      XF_SHR   = 2'd1,
      XF_NSWAP = 2'd2,
      XF_BREV  = 2'd3
   } xform_cmd_e;
endpackage

// File: rtl/porb_xform.sv
module porb_xform
   import porb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xform_cmd_e        cmd,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("porb_xform: DATA_W must be even and at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] shl_v, shr_v, swap_v, brev_v;

   assign shl_v  = {din[DATA_W-2:0], 1'b0};
   assign shr_v  = {1'b0, din[DATA_W-1:1]};
   assign swap_v = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
         assign brev_v[i] = din[DATA_W-1-i];
      end
   endgenerate

   always_comb begin
      unique case (cmd)
         XF_SHL:   dout = shl_v;
         XF_SHR:   dout = shr_v;
         XF_NSWAP: dout = swap_v;
         XF_BREV:  dout = brev_v;
         default:  dout = '0;
      endcase
   end

   // R2
   shr_msb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == XF_SHR) |-> (dout[DATA_W-1] == 1'b0));

   // R3
   nswap_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == XF_NSWAP) |-> ($countones(dout) == $countones(din)));

   // R4
   brev_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == XF_BREV) |-> (dout[0] == din[DATA_W-1] &&
                            $countones(dout) == $countones(din)));
endmodule

// File: rtl/porb_cmdregs.sv
module porb_cmdregs #(
   parameter int DATA_W = 8,
   parameter int CMD_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel_cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] data_q,
   output logic [CMD_W-1:0]  cmd_q
);
   generate
      if (CMD_W > DATA_W) begin : g_bad_cmd
         $error("porb_cmdregs: CMD_W may not exceed DATA_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         cmd_q  <= '0;
      end else if (wr_en) begin
         if (sel_cmd) cmd_q  <= wdata[CMD_W-1:0];
         else         data_q <= wdata;
      end
   end

   // R1
   cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_cmd) |=> (cmd_q == $past(wdata[CMD_W-1:0]) && $stable(data_q)));

   // R1
   data_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel_cmd) |=> (data_q == $past(wdata) && $stable(cmd_q)));

   // R10
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(data_q) && $stable(cmd_q)));
endmodule

// File: rtl/porb_bank.sv
module porb_bank #(
   parameter int ADDR_W     = 24,
   parameter int BANK_W     = 8,
   parameter int BANK_SHIFT = 15,
   parameter int GUARD      = 32'h10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wbyte,
   input  logic [ADDR_W:0]   rom_size,
   output logic [ADDR_W-1:0] bank_q,
   output logic              reject_q
);
   localparam int SUM_W = ADDR_W + 1;

   generate
      if (BANK_W + BANK_SHIFT > ADDR_W) begin : g_bad_bank
         $error("porb_bank: bank does not fit the address width");
      end
      if (GUARD <= 0) begin : g_bad_guard
         $error("porb_bank: GUARD must be positive");
      end
   endgenerate

   logic [SUM_W-1:0] cand, need;
   logic             too_far;

   assign cand    = SUM_W'(wbyte) << BANK_SHIFT;
   assign need    = cand + SUM_W'(GUARD);
   assign too_far = (need >= rom_size);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q   <= '0;
         reject_q <= 1'b0;
      end else begin
         reject_q <= wr_en && too_far;
         if (wr_en && !too_far) bank_q <= cand[ADDR_W-1:0];
      end
   end

   // R7
   reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject_q |-> (bank_q == $past(bank_q)));

   // R7
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject_q |-> $past(wr_en));

   // R10
   bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/porb_remap.sv
module porb_remap #(
   parameter int ADDR_W      = 24,
   parameter int REMAP_LIMIT = 32'h100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [ADDR_W-1:0] bank,
   output logic [ADDR_W-1:0] phys_addr
);
   localparam int LIM_LOG = $clog2(REMAP_LIMIT);
   localparam bit LIM_POW2 = ((REMAP_LIMIT & (REMAP_LIMIT - 1)) == 0);

   logic in_low;

   generate
      if (REMAP_LIMIT <= 0 || LIM_LOG >= ADDR_W) begin : g_bad_limit
         $error("porb_remap: REMAP_LIMIT out of range");
      end
      if (LIM_POW2) begin : g_pow2
         assign in_low = (cpu_addr[ADDR_W-1:LIM_LOG] == '0);
      end else begin : g_cmp
         assign in_low = (cpu_addr < ADDR_W'(REMAP_LIMIT));
      end
   endgenerate

   assign phys_addr = in_low ? (cpu_addr | bank) : cpu_addr;

   // R6
   phys_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phys_addr & cpu_addr) == cpu_addr));

   // R6
   zero_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank == '0) |-> (phys_addr == cpu_addr));
endmodule

// File: rtl/xform_orbank_unit.sv
module xform_orbank_unit
   import porb_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 8,
   parameter int CMD_W       = 2,
   parameter int PAGE_SHIFT  = 20,
   parameter int PROT_PAGE   = 6,
   parameter int BANK_PAGE   = 7,
   parameter int SEL_BIT     = 1,
   parameter int BANK_SHIFT  = 15,
   parameter int GUARD       = 32'h10000,
   parameter int REMAP_LIMIT = 32'h100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W:0]   rom_size,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              bank_reject
);
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

   generate
      if (CMD_W != 2) begin : g_bad_cmdw
         $error("xform_orbank_unit: four transforms need CMD_W of 2");
      end
      if (PROT_PAGE == BANK_PAGE) begin : g_bad_pages
         $error("xform_orbank_unit: pages must differ");
      end
      if (SEL_BIT >= PAGE_SHIFT) begin : g_bad_sel
         $error("xform_orbank_unit: select bit inside page field");
      end
   endgenerate

   logic [PAGE_W-1:0] page;
   logic              prot_wr, bank_wr, in_rd_win;
   logic [DATA_W-1:0] data_q, xf_out;
   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] bank_q;

   assign page      = cpu_addr[ADDR_W-1:PAGE_SHIFT];
   assign prot_wr   = wr_en && (page == PAGE_W'(PROT_PAGE));
   assign bank_wr   = wr_en && (page == PAGE_W'(BANK_PAGE));
   assign in_rd_win = (page == PAGE_W'(PROT_PAGE)) || (page == PAGE_W'(BANK_PAGE));

   porb_cmdregs #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(prot_wr), .sel_cmd(cpu_addr[SEL_BIT]),
      .wdata(wr_data), .data_q(data_q), .cmd_q(cmd_q));

   porb_xform #(.DATA_W(DATA_W)) u_xf (
      .clk(clk), .rst_n(rst_n), .cmd(xform_cmd_e'(cmd_q)), .din(data_q), .dout(xf_out));

   porb_bank #(.ADDR_W(ADDR_W), .BANK_W(DATA_W), .BANK_SHIFT(BANK_SHIFT), .GUARD(GUARD)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .wbyte(wr_data), .rom_size(rom_size),
      .bank_q(bank_q), .reject_q(bank_reject));

   porb_remap #(.ADDR_W(ADDR_W), .REMAP_LIMIT(REMAP_LIMIT)) u_map (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bank(bank_q), .phys_addr(phys_addr));

   assign rd_data = in_rd_win ? xf_out : '0;

   // R10
   bank_write_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |=> ($stable(data_q) && $stable(cmd_q)));

   // R10
   prot_write_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_wr |=> ($stable(bank_q) && !bank_reject));

   // R7
   reject_needs_bank_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_reject |-> $past(bank_wr));
endmodule

// File: tb/sim_xform_orbank_unit.sv
`timescale 1ns/1ps
module sim_xform_orbank_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [24:0] rom_size = 25'h200000;
   logic [23:0] phys_addr;
   logic        bank_reject;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   xform_orbank_unit u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .rom_size(rom_size), .phys_addr(phys_addr), .bank_reject(bank_reject));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int xf(input int cmd, input int d);
      int r = 0;
      case (cmd)
         0: r = (d * 2) % 256;
         1: r = d / 2;
         2: r = ((d % 16) * 16) + (d / 16);
         default: for (int i = 0; i < 8; i++) if (((d >> i) & 1) != 0) r += (1 << (7 - i));
      endcase
      return r;
   endfunction

   task automatic do_write(input logic [23:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         finish_run();
      end
   end

   int exp_bank, exp_data, exp_cmd;

   task automatic bank_sweep(input int rs);
      rom_size = rs[24:0];
      for (int v = 0; v < 256; v++) begin
         int rej;
         rej = ((v * 32'h8000 + 32'h10000) >= rs) ? 1 : 0;
         @(negedge clk);
         cpu_addr = 24'h700000 | 24'(v << 4); wr_data = 8'(v); wr_en = 1'b1;
         #1;
         // R5 and R10: readback during the bank write shows the stored data transform
         chk("R5 read during bank write", int'(rd_data), xf(exp_cmd, exp_data));
         @(negedge clk);
         wr_en = 1'b0;
         if (rej == 0) exp_bank = v * 32'h8000;
         chk("R7 reject flag", int'(bank_reject), rej);
         cpu_addr = 24'h012345; #1;
         chk("R6 low remap OR", int'(phys_addr), exp_bank | 32'h012345);
         cpu_addr = 24'h0FFFFF; #1;
         chk("R6 top of low region", int'(phys_addr), exp_bank | 32'h0FFFFF);
         cpu_addr = 24'h123456; #1;
         chk("R6 above 1MB passthrough", int'(phys_addr), 32'h123456);
      end
      @(negedge clk);
      chk("R7 flag drops after idle", int'(bank_reject), 0);
      cpu_addr = 24'h600000; #1;
      chk("R10 data and command kept over bank writes", int'(rd_data), xf(exp_cmd, exp_data));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cpu_addr = 24'h0ABCDE; #1;
      // R8 reset state
      chk("R8 bank zero at reset", int'(phys_addr), 32'h0ABCDE);
      chk("R8 no reject at reset", int'(bank_reject), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cpu_addr = 24'h600000; #1;
      chk("R8 data zero at reset", int'(rd_data), 0);

      // R1 R2 R3 R4 R9: full sweep of command and data
      for (int c = 0; c < 4; c++) begin
         do_write(24'h600002 | 24'(c << 8), 8'hA4 | 8'(c));
         exp_cmd = c;
         for (int d = 0; d < 256; d++) begin
            do_write(24'h600000 | 24'((d << 4) & 32'hFFFF0), 8'(d));
            exp_data = d;
            cpu_addr = ((d % 2) == 0) ? 24'h6ABCD1 : 24'h7F0003; #1;
            case (c)
               0: chk("R2 shift left", int'(rd_data), xf(0, d));
               1: chk("R2 shift right", int'(rd_data), xf(1, d));
               2: chk("R3 nibble swap", int'(rd_data), xf(2, d));
               default: chk("R4 bit mirror", int'(rd_data), xf(3, d));
            endcase
         end
      end

      // R9: value visible only after the taking edge
      @(negedge clk);
      cpu_addr = 24'h600000; wr_data = 8'h0F; wr_en = 1'b1; #1;
      chk("R9 old value before edge", int'(rd_data), xf(exp_cmd, exp_data));
      @(negedge clk); wr_en = 1'b0; exp_data = 8'h0F; #1;
      chk("R9 new value after edge", int'(rd_data), xf(exp_cmd, exp_data));

      // R5 outside the read window
      cpu_addr = 24'h5FFFFF; #1; chk("R5 below window", int'(rd_data), 0);
      cpu_addr = 24'h800000; #1; chk("R5 above window", int'(rd_data), 0);
      cpu_addr = 24'h000000; #1; chk("R5 low ROM", int'(rd_data), 0);

      // R6 R7 R10 over three ROM sizes
      exp_bank = 0;
      bank_sweep(32'h200000);
      bank_sweep(32'h400000);
      bank_sweep(32'h100000);

      // R7 exact boundary at 4 MB
      rom_size = 25'h400000;
      do_write(24'h700000, 8'h7D);
      chk("R7 last accepted bank", int'(bank_reject), 0);
      exp_bank = 32'h7D * 32'h8000;
      do_write(24'h700000, 8'h7E);
      chk("R7 first refused bank", int'(bank_reject), 1);
      cpu_addr = 24'h000000; #1;
      chk("R7 refused bank keeps old", int'(phys_addr), exp_bank);

      // R10 protection writes leave the bank alone
      do_write(24'h600002, 8'h01);
      do_write(24'h600000, 8'hC3);
      cpu_addr = 24'h000010; #1;
      chk("R10 bank kept after protection writes", int'(phys_addr), exp_bank | 32'h10);
      cpu_addr = 24'h700000; #1;
      chk("R1 command 1 on C3", int'(rd_data), 32'h61);

      // R8 reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cpu_addr = 24'h054321; #1;
      chk("R8 bank cleared by reset", int'(phys_addr), 32'h054321);
      do_write(24'h600000, 8'h81);
      cpu_addr = 24'h600000; #1;
      chk("R8 command cleared by reset", int'(rd_data), 32'h02);

      finish_run();
   end
endmodule